// File: doc/BRIEF.md
# Negacyclic Polynomial Multiplier with Carry-Save Accumulation

This block multiplies a polynomial of `N` public coefficients (13 bits each) by a polynomial of `N` small secret coefficients. The product is taken modulo x^N + 1, and all coefficient arithmetic is modulo 2^13. It serves a lattice key encapsulation datapath whose moduli are powers of two. Reduction is therefore plain truncation, and no modular-reduction logic is present.

One multiply-accumulate path is reused for every coefficient product. The block works through the result coefficients one at a time. For each result index k it reads public coefficient i and secret coefficient (k − i) mod N on every cycle. A product whose indices sum past N − 1 wraps around and is subtracted.

Partial products come from shifts and inversion, not from a multiplier. They are folded into a 13-bit sum/carry register pair through two 3:2 compressor levels, so no carry travels along the word during accumulation. Each coefficient goes through a single carry-propagate addition only once, when it is written out. Both coefficient memories are external and must have a one-cycle synchronous read.

Top module: `polymul_csa_mac`

## Requirements
- R1: After a synchronous active-low reset, `done` and `res_we` are 0, and no write appears until `start` is asserted.
- R2: The value written for index k equals Σ pub[i]·sec[j] over i+j = k, minus Σ pub[i]·sec[j] over i+j = k+N, taken modulo 2^13.
- R3: Each secret coefficient is a 4-bit two's-complement value in the range −4 to +4. Every value in that range, including the negative ones, contributes its signed product.
- R4: A run writes exactly N coefficients, one per write strobe, in ascending index order 0, 1, …, N−1.
- R5: `done` is high for exactly one cycle, in the cycle after the last result write.
- R6: If `start` is sampled at clock edge E, then `done` is high in the cycle that follows edge E + N·(N+2). Result index k is written in the cycle that follows edge E + (k+1)·(N+2) − 1.
- R7: A `start` pulse while a run is in progress is ignored. The write sequence and the timing of `done` are unchanged.
- R8: Accumulation overflow past bit 12 is discarded. Operands at full scale (public 8191, secret −4 or +4) give the truncated result of R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Starts a multiplication when the block is idle |
| done | output | 1 | One-cycle pulse after the last result write |
| pub_addr | output | log2(N) | Read address into the public-coefficient memory |
| pub_data | input | 13 | Public coefficient, valid one cycle after its address |
| sec_addr | output | log2(N) | Read address into the secret-coefficient memory |
| sec_data | input | 4 | Secret coefficient (two's complement), valid one cycle after its address |
| res_we | output | 1 | Result write strobe |
| res_addr | output | log2(N) | Result coefficient index |
| res_data | output | 13 | Result coefficient value |

## Verification
The hardest case to reach is the negative-increment path. It occurs when a wrapped index (i > k) is combined with a negative secret coefficient, which makes the term positive again. It also occurs when the inverted operand and the carry-in injection meet a zero second addend, as with magnitudes 1, 2 and 4. A uniform random spread of secrets over −4 to +4 reaches every sign and magnitude combination at every result index within one full-size run. A second run puts all operands at full scale, forcing the sum/carry pair to overflow on nearly every cycle. A redundant `start` is pulsed in the middle of the first run to confirm that it is ignored.

// File: rtl/pmac_pkg.sv
// Package: shared types for the carry-save polynomial multiplier.
// Assumes nothing beyond IEEE 1800-2017 enums.
package pmac_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_FLUSH,
        ST_WRITE,
        ST_DONE
    } pmac_state_e;
endpackage

// File: rtl/pmac_csa.sv
// 3:2 compressor over W bits. The carry vector is shifted up one place,
// and the vacated bit 0 takes `cin`, which is used to inject +1 for a
// two's-complement negation. The carry out of the top bit is dropped
// because the arithmetic is modulo 2^W.
module pmac_csa #(
    parameter int W = 13
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic [W-1:0] c
);
    logic [W-1:0] maj;

    // Bitwise sum and majority: no carry crosses a bit position here.
    always_comb begin
        s   = x ^ y ^ z;
        maj = (x & y) | (x & z) | (y & z);
        c   = {maj[W-2:0], cin};
    end
endmodule

// File: rtl/pmac_ppgen.sv
// Partial-product former. It turns |secret| * public into two addends
// that are shifted copies of the public value (3a = 2a + a). It inverts
// them when the effective sign is negative; the accumulator adds the
// matching +1 +1 through its two carry-in slots. Assumes |secret| <= 4.
module pmac_ppgen #(
    parameter int QW = 13,
    parameter int SW = 4
) (
    input  logic [QW-1:0] pub,
    input  logic [SW-1:0] sec,
    input  logic          wrap,
    output logic [QW-1:0] t0,
    output logic [QW-1:0] t1,
    output logic          neg
);
    logic [SW-1:0] mag;
    logic [QW-1:0] r0, r1;

    // Select the shifted addends by magnitude, then apply the sign.
    always_comb begin
        mag = sec[SW-1] ? (~sec + 1'b1) : sec;
        r0  = '0;
        r1  = '0;
        if (mag == SW'(1)) begin
            r0 = pub;
        end else if (mag == SW'(2)) begin
            r0 = {pub[QW-2:0], 1'b0};
        end else if (mag == SW'(3)) begin
            r0 = {pub[QW-2:0], 1'b0};
            r1 = pub;
        end else if (mag == SW'(4)) begin
            r0 = {pub[QW-3:0], 2'b00};
        end
        neg = sec[SW-1] ^ wrap;
        t0  = neg ? ~r0 : r0;
        t1  = neg ? ~r1 : r1;
    end
endmodule

// File: rtl/pmac_acc.sv
// Redundant accumulator. It holds a sum/carry pair and folds in two
// addends per valid cycle through two compressor levels. Its output
// is the single carry-propagate resolution of the pair. Assumes `clr`
// and `vld` are never high together.
module pmac_acc #(
    parameter int QW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          vld,
    input  logic [QW-1:0] t0,
    input  logic [QW-1:0] t1,
    input  logic          neg,
    output logic [QW-1:0] res
);
    logic [QW-1:0] sum_q, carry_q;
    logic [QW-1:0] s1, c1, s2, c2;

    pmac_csa #(.W(QW)) u_lvl1 (
        .x(sum_q), .y(carry_q), .z(t0), .cin(neg), .s(s1), .c(c1)
    );
    pmac_csa #(.W(QW)) u_lvl2 (
        .x(s1), .y(c1), .z(t1), .cin(neg), .s(s2), .c(c2)
    );

    // Keep the pair redundant: load it on valid, zero it on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sum_q   <= '0;
            carry_q <= '0;
        end else if (vld) begin
            sum_q   <= s2;
            carry_q <= c2;
        end
    end

    // Final carry-propagate addition, truncated to QW bits.
    always_comb res = sum_q + carry_q;

    // R2: the pair changes only on a valid product or a clear.
    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!vld && !clr) |=> ($stable(sum_q) && $stable(carry_q)));
endmodule

// File: rtl/pmac_ctrl.sv
// Sequencer. For each result index k it walks the public index i
// from 0 to N-1, addressing secret (k - i) mod N. It then allows one
// flush cycle for the memory latency and one write cycle. Assumes N is
// a power of two, so address subtraction wraps naturally.
module pmac_ctrl
    import pmac_pkg::*;
#(
    parameter int N  = 256,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic [AW-1:0] pub_addr,
    output logic [AW-1:0] sec_addr,
    output logic          vld,
    output logic          wrap,
    output logic          clr,
    output logic          res_we,
    output logic [AW-1:0] res_addr,
    output logic          done
);
    localparam logic [AW-1:0] LAST = AW'(N - 1);

    pmac_state_e   state;
    logic [AW-1:0] k_q, i_q;

    // State and index counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            k_q   <= '0;
            i_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_RUN;
                    k_q   <= '0;
                    i_q   <= '0;
                end
                ST_RUN: begin
                    i_q <= i_q + 1'b1;
                    if (i_q == LAST) state <= ST_FLUSH;
                end
                ST_FLUSH: state <= ST_WRITE;
                ST_WRITE: begin
                    if (k_q == LAST) begin
                        state <= ST_DONE;
                    end else begin
                        k_q   <= k_q + 1'b1;
                        state <= ST_RUN;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Align the valid flag and wrap flag with the memory read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld  <= 1'b0;
            wrap <= 1'b0;
        end else begin
            vld  <= (state == ST_RUN);
            wrap <= (i_q > k_q);
        end
    end

    // Address and strobe decode.
    always_comb begin
        pub_addr = i_q;
        sec_addr = k_q - i_q;
        clr      = (state == ST_WRITE);
        res_we   = (state == ST_WRITE);
        res_addr = k_q;
        done     = (state == ST_DONE);
    end

    // R5: done never lasts more than one cycle.
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R5: done follows directly on a write.
    a_r5_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(res_we));
    // R4: two writes are never back to back.
    a_r4_write_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |=> !res_we);
    // R7: start during a run leaves the result index alone.
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state == ST_RUN) |=> $stable(k_q));
endmodule

// File: rtl/polymul_csa_mac.sv
// Top level: a negacyclic polynomial multiplier with one shared,
// carry-save multiply-accumulate path. Assumes both coefficient
// memories return data one cycle after the address.
module polymul_csa_mac #(
    parameter int N  = 256,
    parameter int QW = 13,
    parameter int SW = 4,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          done,
    output logic [AW-1:0] pub_addr,
    input  logic [QW-1:0] pub_data,
    output logic [AW-1:0] sec_addr,
    input  logic [SW-1:0] sec_data,
    output logic          res_we,
    output logic [AW-1:0] res_addr,
    output logic [QW-1:0] res_data
);
    logic          vld, wrap, clr, neg;
    logic [QW-1:0] t0, t1;

    pmac_ctrl #(.N(N), .AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .pub_addr(pub_addr), .sec_addr(sec_addr),
        .vld(vld), .wrap(wrap), .clr(clr),
        .res_we(res_we), .res_addr(res_addr), .done(done)
    );

    pmac_ppgen #(.QW(QW), .SW(SW)) u_ppgen (
        .pub(pub_data), .sec(sec_data), .wrap(wrap),
        .t0(t0), .t1(t1), .neg(neg)
    );

    pmac_acc #(.QW(QW)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(clr), .vld(vld),
        .t0(t0), .t1(t1), .neg(neg), .res(res_data)
    );

    // R3: only secret coefficients in -4..+4 are consumed.
    a_r3_secret_range: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> ($signed(sec_data) >= -4 && $signed(sec_data) <= 4));
endmodule

// File: tb/polymul_csa_mac_test.sv
// Scoreboard bench: the driver computes a negacyclic reference and
// queues the expected writes; the monitor pops and compares them.
module polymul_csa_mac_test;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 256;
    localparam int QW = 13;
    localparam int SW = 4;
    localparam int AW = $clog2(N);
    localparam int WATCHDOG = 190000;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [QW-1:0] data;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          done, res_we;
    logic [AW-1:0] pub_addr, sec_addr, res_addr;
    logic [QW-1:0] pub_data, res_data;
    logic [SW-1:0] sec_data;

    logic [QW-1:0] pmem [N];
    logic [SW-1:0] smem [N];
    item_t         exp_q [$];

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    int n_done = 0;
    int start_edge = 0;
    bit armed = 1'b0;
    bit done_prev = 1'b0;

    polymul_csa_mac #(.N(N), .QW(QW), .SW(SW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done),
        .pub_addr(pub_addr), .pub_data(pub_data),
        .sec_addr(sec_addr), .sec_data(sec_data),
        .res_we(res_we), .res_addr(res_addr), .res_data(res_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Synchronous-read memory models.
    always @(posedge clk) begin
        pub_data <= pmem[pub_addr];
        sec_data <= smem[sec_addr];
    end

    // Driver: compute the reference, queue it, then pulse start.
    task automatic run_case(input bit extra_start);
        int acc [N];
        int prev;
        for (int k = 0; k < N; k++) acc[k] = 0;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                int p;
                p = int'(pmem[i]) * int'($signed(smem[j]));
                if (i + j < N) acc[i + j] += p;
                else acc[i + j - N] -= p;
            end
        end
        for (int k = 0; k < N; k++) begin
            item_t it;
            it.addr = AW'(k);
            it.data = QW'(acc[k]);
            exp_q.push_back(it);
        end
        prev = n_done;
        @(negedge clk);
        start = 1'b1;
        start_edge = cyc + 1;
        armed = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (extra_start) begin
            repeat (1000) @(negedge clk);
            start = 1'b1; // R7: redundant start mid-run
            @(negedge clk);
            start = 1'b0;
        end
        while (n_done == prev) @(negedge clk);
        @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R4: writes missing, actual %0d expected 0 left", exp_q.size());
            exp_q.delete();
        end
    endtask

    // Monitor: compare writes and done timing away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (res_we) begin
                n_checks++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R1/R4: unexpected write addr %0d data %0d, expected none",
                             res_addr, res_data);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    if (res_addr != e.addr || res_data != e.data) begin
                        n_fail++;
                        $display("FAIL R2/R3/R4/R8: actual addr %0d data %0d, expected addr %0d data %0d",
                                 res_addr, res_data, e.addr, e.data);
                    end
                    // R6: write cycle of index k
                    n_checks++;
                    if (cyc != start_edge + (int'(e.addr) + 1) * (N + 2) - 1) begin
                        n_fail++;
                        $display("FAIL R6: write %0d at cycle %0d, expected %0d", e.addr,
                                 cyc - start_edge, (int'(e.addr) + 1) * (N + 2) - 1);
                    end
                end
            end
            if (done) begin
                n_done++;
                n_checks++;
                if (!armed || cyc != start_edge + N * (N + 2)) begin
                    n_fail++;
                    $display("FAIL R5/R6: done at cycle %0d, expected %0d",
                             cyc - start_edge, N * (N + 2));
                end
                armed = 1'b0;
                if (done_prev) begin
                    n_fail++;
                    $display("FAIL R5: done high two cycles, actual 1 expected 0");
                end
            end
            done_prev = done;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            pmem[i] = '0;
            smem[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        n_checks++;
        if (done !== 1'b0 || res_we !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: done=%0b res_we=%0b, expected 0 0", done, res_we);
        end
        repeat (10) @(negedge clk); // R1: monitor flags any write here

        // R2, R3, R7: random public values, secrets across -4..+4
        for (int i = 0; i < N; i++) begin
            pmem[i] = QW'($urandom);
            smem[i] = SW'($urandom_range(0, 8) - 4);
        end
        smem[0] = SW'(-4);
        smem[1] = SW'(4);
        smem[N-1] = SW'(-3);
        run_case(1'b1);

        // R8: full-scale operands, heavy overflow
        for (int i = 0; i < N; i++) begin
            pmem[i] = '1;
            smem[i] = (i % 2 == 0) ? SW'(-4) : SW'(4);
        end
        smem[N-2] = SW'(-4);
        run_case(1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule